// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an already unpacked floating-point operand into a signed two's-complement integer. The operand arrives as a class code, a sign, an unbiased exponent, a significand and a sticky bit. The integer is 32 or 64 bits wide, and the width is chosen separately for each conversion. The conversion always chops toward zero, whatever rounding mode the rest of the floating-point unit is using. Alongside the integer it reports two flags. One says the value lost fractional bits. The other says the value could not be represented.

Operands that cannot be represented give a saturated result that depends on the sign. Positive operands give the largest positive integer, and negative operands give the most negative integer. Infinity and NaN are handled the same way as values that are too large. When the result saturates, the invalid flag is raised and the inexact flag is suppressed. The block sits at the end of an arithmetic pipeline. A conversion is launched by pulsing `in_valid`, and the result comes back on the next cycle, qualified by `out_valid`.

Top module: `f2i_trunc`

## Requirements
- R1: Class code 2'b00 (zero) gives `out_data` = 0 with both `out_inexact` and `out_invalid` low.
- R2: For class code 2'b01 (number), an exponent at or above the selected width (32 when `in_wide`=0, 64 when `in_wide`=1) is an overflow.
- R3: Otherwise the result is the integer part of the significand times 2^exponent, where significand bit SIG_W-1 carries weight 2^exponent. This magnitude is negated when `in_sign`=1. `out_inexact` is high when any discarded bit or `in_sticky` is set, and this includes negative exponents, whose result is 0.
- R4: A magnitude of 2^(N-1)+sign or more overflows. So +2^(N-1) overflows, and -2^(N-1) converts exactly.
- R5: On overflow `out_invalid` is 1 and `out_inexact` is 0. `out_data` is 2^(N-1)-1 for a positive operand and -2^(N-1) for a negative one.
- R6: Class codes 2'b10 (infinity) and 2'b11 (NaN) always overflow under the rule of R5.
- R7: `out_inexact` and `out_invalid` are never high together.
- R8: In 32-bit mode the result is sign-extended across the whole 64-bit `out_data`. The width select applies to each item independently.
- R9: Each conversion takes exactly one cycle: `out_valid` equals `in_valid` of the previous cycle, and back-to-back items are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W (12) | Signed unbiased exponent |
| in_sig | input | SIG_W (66) | Significand; top bit weighs 2^exponent |
| in_sticky | input | 1 | OR of bits already lost below the significand |
| in_wide | input | 1 | 0 = 32-bit result, 1 = 64-bit result |
| out_valid | output | 1 | Result present |
| out_data | output | WIDE_W (64) | Signed integer result |
| out_inexact | output | 1 | Fractional bits were discarded |
| out_invalid | output | 1 | Operand not representable, result saturated |

## Verification
The checker looks at every cycle. It confirms that zero operands come out clean, that infinity, NaN and oversized exponents raise invalid, and that every invalid result equals the saturation value for the registered sign and width. It also confirms that the two flags never appear together, that narrow results are sign-extended, and that the one-cycle valid latency holds. Several things can only be shown by the scoreboard scenarios: the truncated magnitude itself, whether inexact is raised for a given pattern of discarded bits, and the asymmetric boundary at ±2^(N-1), including the case just below -2^31.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
   typedef enum logic [1:0] {
      FC_ZERO = 2'd0,
      FC_NUM  = 2'd1,
      FC_INF  = 2'd2,
      FC_NAN  = 2'd3
   } fclass_e;
endpackage

// File: rtl/f2i_align.sv
// Moves the integer part of the significand into the low bits and reports
// whether any set bit was discarded on the way.
module f2i_align #(
   parameter int SIG_W  = 66,
   parameter int EXP_W  = 12,
   parameter int WIDE_W = 64
) (
   input  logic signed [EXP_W-1:0] exp_i,
   input  logic [SIG_W-1:0]        sig_i,
   output logic [WIDE_W-1:0]       mag_o,
   output logic                    lost_o
);
   localparam int SHW = $clog2(SIG_W + 1);
   localparam logic signed [EXP_W-1:0] WIDE_E = EXP_W'(WIDE_W);

   logic [SHW-1:0]   sh;
   logic [SIG_W-1:0] drop_mask;

   always_comb begin
      if (exp_i < 0)
         sh = SHW'(SIG_W);                 // everything is fraction
      else if (exp_i >= WIDE_E)
         sh = '0;                          // overflow path, value unused
      else
         sh = SHW'(SIG_W - 1) - SHW'(exp_i);
      drop_mask = ~({SIG_W{1'b1}} << sh);
      mag_o     = WIDE_W'(sig_i >> sh);
      lost_o    = |(sig_i & drop_mask);
   end
endmodule

// File: rtl/f2i_range.sv
// Range check, saturation, sign application and flag selection.
module f2i_range
   import f2i_pkg::*;
#(
   parameter int EXP_W    = 12,
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32
) (
   input  fclass_e                 cls_i,
   input  logic                    sign_i,
   input  logic signed [EXP_W-1:0] exp_i,
   input  logic [WIDE_W-1:0]       mag_i,
   input  logic                    lost_i,
   input  logic                    sticky_i,
   input  logic                    wide_i,
   output logic [WIDE_W-1:0]       res_o,
   output logic                    inexact_o,
   output logic                    invalid_o
);
   localparam logic signed [EXP_W-1:0] WIDE_E   = EXP_W'(WIDE_W);
   localparam logic signed [EXP_W-1:0] NARROW_E = EXP_W'(NARROW_W);
   localparam logic [WIDE_W-1:0] WIDE_MAX   = {1'b0, {(WIDE_W-1){1'b1}}};
   localparam logic [WIDE_W-1:0] NARROW_MAX = WIDE_W'({(NARROW_W-1){1'b1}});

   logic [WIDE_W-1:0] lim_mag;
   logic [WIDE_W-1:0] sat_max;
   logic              exp_big;
   logic              ovf;

   always_comb begin
      sat_max = wide_i ? WIDE_MAX : NARROW_MAX;
      lim_mag = sat_max + WIDE_W'(1) + WIDE_W'(sign_i);
      exp_big = exp_i >= (wide_i ? WIDE_E : NARROW_E);
      unique case (cls_i)
         FC_ZERO: ovf = 1'b0;
         FC_NUM:  ovf = exp_big || (mag_i >= lim_mag);
         default: ovf = 1'b1;
      endcase
      invalid_o = ovf;
      inexact_o = (cls_i == FC_NUM) && !ovf && (lost_i || sticky_i);
      if (ovf)
         res_o = sign_i ? ~sat_max : sat_max;
      else if (cls_i == FC_ZERO)
         res_o = '0;
      else
         res_o = sign_i ? (WIDE_W'(0) - mag_i) : mag_i;
   end
endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc
   import f2i_pkg::*;
#(
   parameter int SIG_W    = 66,
   parameter int EXP_W    = 12,
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32,
   parameter bit PIPE     = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [1:0]              in_class,
   input  logic                    in_sign,
   input  logic signed [EXP_W-1:0] in_exp,
   input  logic [SIG_W-1:0]        in_sig,
   input  logic                    in_sticky,
   input  logic                    in_wide,
   output logic                    out_valid,
   output logic [WIDE_W-1:0]       out_data,
   output logic                    out_inexact,
   output logic                    out_invalid
);
   if (SIG_W < WIDE_W + 1) begin : g_bad_sig
      $error("f2i_trunc: SIG_W must exceed WIDE_W");
   end
   if (NARROW_W >= WIDE_W) begin : g_bad_narrow
      $error("f2i_trunc: NARROW_W must be below WIDE_W");
   end
   if ((2 ** (EXP_W - 1)) <= WIDE_W) begin : g_bad_exp
      $error("f2i_trunc: EXP_W too small to hold WIDE_W");
   end

   logic [WIDE_W-1:0] mag;
   logic              lost;
   logic [WIDE_W-1:0] res;
   logic              res_inx;
   logic              res_inv;

   f2i_align #(.SIG_W(SIG_W), .EXP_W(EXP_W), .WIDE_W(WIDE_W)) u_align (
      .exp_i  (in_exp),
      .sig_i  (in_sig),
      .mag_o  (mag),
      .lost_o (lost)
   );

   f2i_range #(.EXP_W(EXP_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_range (
      .cls_i     (fclass_e'(in_class)),
      .sign_i    (in_sign),
      .exp_i     (in_exp),
      .mag_i     (mag),
      .lost_i    (lost),
      .sticky_i  (in_sticky),
      .wide_i    (in_wide),
      .res_o     (res),
      .inexact_o (res_inx),
      .invalid_o (res_inv)
   );

   if (PIPE) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_inexact <= 1'b0;
            out_invalid <= 1'b0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) begin
               out_data    <= res;
               out_inexact <= res_inx;
               out_invalid <= res_inv;
            end
         end
      end
   end else begin : g_comb
      assign out_valid   = in_valid;
      assign out_data    = res;
      assign out_inexact = res_inx;
      assign out_invalid = res_inv;
   end
endmodule

// File: rtl/f2i_trunc_chk.sv
module f2i_trunc_chk #(
   parameter int EXP_W    = 12,
   parameter int WIDE_W   = 64,
   parameter int NARROW_W = 32,
   parameter bit PIPE     = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [1:0]              in_class,
   input logic                    in_sign,
   input logic signed [EXP_W-1:0] in_exp,
   input logic                    in_wide,
   input logic                    out_valid,
   input logic [WIDE_W-1:0]       out_data,
   input logic                    out_inexact,
   input logic                    out_invalid
);
   localparam logic signed [EXP_W-1:0] WIDE_E   = EXP_W'(WIDE_W);
   localparam logic signed [EXP_W-1:0] NARROW_E = EXP_W'(NARROW_W);

   if (PIPE) begin : g_chk
      logic                    q_vld, q_sign, q_wide;
      logic [1:0]              q_class;
      logic signed [EXP_W-1:0] q_exp;
      logic [WIDE_W-1:0]       q_max;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_vld   <= 1'b0;
            q_sign  <= 1'b0;
            q_wide  <= 1'b0;
            q_class <= 2'd0;
            q_exp   <= '0;
         end else begin
            q_vld   <= in_valid;
            q_sign  <= in_sign;
            q_wide  <= in_wide;
            q_class <= in_class;
            q_exp   <= in_exp;
         end
      end

      assign q_max = q_wide ? {1'b0, {(WIDE_W-1){1'b1}}} : WIDE_W'({(NARROW_W-1){1'b1}});

      AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
         q_vld && q_class == 2'd0 |-> out_data == '0 && !out_inexact && !out_invalid); // R1
      AST_BIG_EXP: assert property (@(posedge clk) disable iff (!rst_n)
         q_vld && q_class == 2'd1 && q_exp >= (q_wide ? WIDE_E : NARROW_E) |-> out_invalid); // R2
      AST_SAT_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && out_invalid |-> out_data == (q_sign ? ~q_max : q_max)); // R5
      AST_NONNUM_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
         q_vld && q_class[1] |-> out_invalid); // R6
      AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> !(out_inexact && out_invalid)); // R7
      AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && !q_wide |->
            out_data[WIDE_W-1:NARROW_W] == {(WIDE_W-NARROW_W){out_data[NARROW_W-1]}}); // R8
      AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         q_vld |-> out_valid); // R9
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
         !q_vld |-> !out_valid); // R9
   end
endmodule

bind f2i_trunc f2i_trunc_chk #(
   .EXP_W(EXP_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .PIPE(PIPE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
   .in_sign(in_sign), .in_exp(in_exp), .in_wide(in_wide),
   .out_valid(out_valid), .out_data(out_data),
   .out_inexact(out_inexact), .out_invalid(out_invalid)
);

// File: tb/f2i_trunc_test.sv
module f2i_trunc_test;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic [1:0]         in_class = 2'd0;
   logic               in_sign = 1'b0;
   logic signed [11:0] in_exp = '0;
   logic [65:0]        in_sig = '0;
   logic               in_sticky = 1'b0;
   logic               in_wide = 1'b0;
   logic               out_valid;
   logic [63:0]        out_data;
   logic               out_inexact;
   logic               out_invalid;

   int n_cmp = 0;
   int n_bad = 0;
   logic [65:0] exp_q[$];
   string       tag_q[$];

   localparam logic [65:0] ONE   = 66'b1 << 65;
   localparam logic [65:0] ONEP5 = 66'b11 << 64;

   always #5 clk = ~clk;

   f2i_trunc uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig), .in_sticky(in_sticky),
      .in_wide(in_wide), .out_valid(out_valid), .out_data(out_data),
      .out_inexact(out_inexact), .out_invalid(out_invalid)
   );

   // Reference: {data[63:0], inexact, invalid}
   function automatic logic [65:0] model(input logic [1:0] c, input logic s, input int e,
                                         input logic [65:0] sig, input logic st, input logic w);
      int n;
      logic [127:0] m, lim;
      logic [63:0] mx, r;
      logic lost;
      n  = w ? 64 : 32;
      mx = w ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
      if (c == 2'd0) return '0;
      if (c[1] || e >= n) return {(s ? ~mx : mx), 1'b0, 1'b1};
      if (e < 0) begin
         m = '0;
         lost = (sig != '0) || st;
      end else begin
         m = {62'b0, sig} >> (65 - e);
         lost = ((m << (65 - e)) != {62'b0, sig}) || st;
      end
      lim = (128'b1 << (n - 1)) + 128'(s);
      if (m >= lim) return {(s ? ~mx : mx), 1'b0, 1'b1};
      r = s ? (64'd0 - m[63:0]) : m[63:0];
      return {r, lost, 1'b0};
   endfunction

   task automatic send(input logic [1:0] c, input logic s, input int e, input logic [65:0] sig,
                       input logic st, input logic w, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_class = c; in_sign = s; in_exp = 12'(e);
      in_sig = sig; in_sticky = st; in_wide = w;
      exp_q.push_back(model(c, s, e, sig, st, w));
      tag_q.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R9: out_valid with nothing expected, got %h", out_data);
         end else begin
            logic [65:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if ({out_data, out_inexact, out_invalid} !== e) begin
               n_bad++;
               $display("FAIL %s: got data=%h inx=%b inv=%b, expected data=%h inx=%b inv=%b",
                        t, out_data, out_inexact, out_invalid, e[65:2], e[1], e[0]);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      n_cmp++;
      if (out_valid !== 1'b0 || out_data !== '0) begin
         n_bad++;
         $display("FAIL reset: got valid=%b data=%h, expected 0/0", out_valid, out_data);
      end
      rst_n = 1'b1;
      idle();

      send(2'd0, 1'b1, 5, ONE, 1'b1, 1'b0, "R1 zero");
      send(2'd1, 1'b0, 0, ONE, 1'b0, 1'b0, "R3 one exact");
      send(2'd1, 1'b1, 3, ONEP5, 1'b0, 1'b0, "R3 minus twelve");
      send(2'd1, 1'b0, 0, ONEP5, 1'b0, 1'b1, "R3 1.5 truncates");
      send(2'd1, 1'b1, -1, ONE, 1'b0, 1'b0, "R3 negative exponent");
      send(2'd1, 1'b0, 0, ONE, 1'b1, 1'b1, "R3 sticky only");
      send(2'd1, 1'b0, 31, ONE, 1'b0, 1'b0, "R4 +2^31 overflows");
      send(2'd1, 1'b1, 31, ONE, 1'b0, 1'b0, "R4 -2^31 exact");
      send(2'd1, 1'b1, 31, ONE | (66'b1 << 33), 1'b0, 1'b0, "R4 -2^31-0.5");
      send(2'd1, 1'b0, 32, ONE, 1'b0, 1'b0, "R2 narrow exp 32");
      send(2'd1, 1'b0, 32, ONE, 1'b0, 1'b1, "R8 wide 2^32");
      send(2'd1, 1'b1, 20, ONEP5, 1'b0, 1'b0, "R8 narrow negative sext");
      send(2'd1, 1'b0, 63, ONE, 1'b0, 1'b1, "R4 +2^63 overflows");
      send(2'd1, 1'b1, 63, ONE, 1'b0, 1'b1, "R4 -2^63 exact");
      send(2'd1, 1'b1, 64, ONE, 1'b1, 1'b1, "R2 wide exp 64");
      send(2'd1, 1'b1, 40, ONE | 66'h1, 1'b0, 1'b0, "R5 sat clears inexact");
      idle();
      send(2'd2, 1'b1, 0, '0, 1'b0, 1'b1, "R6 -inf");
      send(2'd3, 1'b0, 0, ONE, 1'b0, 1'b0, "R6 nan");
      send(2'd1, 1'b0, 40, ONEP5, 1'b0, 1'b1, "R8 wide 1.5*2^40");
      idle();
      idle();

      for (int i = 0; i < 400; i++) begin
         send(2'($urandom % 4), 1'($urandom), int'($urandom % 76) - 6,
              {1'b1, $urandom, $urandom, 1'($urandom)}, 1'($urandom % 3 == 0),
              1'($urandom), "R3 R7 random");
         if (i % 7 == 0) idle();
      end
      idle();
      idle();

      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R9: %0d results outstanding, expected 0", exp_q.size());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule